// File: doc/BRIEF.md
# Three-Wire Handshake Byte Transfer Engine

This block moves bytes between a host and a small device-side controller through a byte-wide shift register. Three active-low control lines set the pace. The host drives a busy line that marks a transfer and an acknowledge line. The device drives a request line. The host also drives a direction input that says whether it is sending bytes to the device or fetching bytes from it. No shift clock is used. Whenever the busy line is asserted, every change of level on the acknowledge or busy line moves exactly one byte.

When the host sends, each byte is captured into a packet buffer. The packet is announced, with its length, when the busy line is released. When the host fetches, bytes are handed out one at a time from a response buffer that the device side has preloaded. The request line goes high once the last byte has been handed out, so it also marks the end of the data. Every byte moved and every transfer boundary arms a shift interrupt. This interrupt fires after a programmable number of cycles, or on the next edge when bypass mode is selected. The meaning of the packet contents is decided outside this block.

Top module: `hs_xfer_engine`

## Requirements
- R1: After reset, `req_n_o` is 1, `sr_irq_o` is 0, `pkt_done_o` is 0 and `shift_out_o` is 0.
- R2: While `busy_n_i` is 0 and `host_to_dev_i` is 1, a change in `ack_n_i` or `busy_n_i` between two sampled cycles writes `shift_in_i` into the packet buffer. The write goes to the next index, starting at 0, and arms an interrupt.
- R3: When the packet buffer already holds DEPTH bytes, a further change captures nothing, overwrites nothing and arms no interrupt.
- R4: While `busy_n_i` is 0, `host_to_dev_i` is 0 and unread response bytes remain, each change loads the next response byte onto `shift_out_o` and arms an interrupt. When no bytes remain, a change leaves `shift_out_o` unchanged and arms nothing.
- R5: `req_n_o` goes to 1 on the same edge that loads the last response byte.
- R6: When `busy_n_i` goes from 0 to 1, an interrupt is always armed. If at least one byte was captured, `pkt_done_o` pulses for one cycle with `pkt_len_o` equal to the byte count, and the capture index returns to 0.
- R7: When `busy_n_i` goes from 0 to 1 and response bytes remain unread, `req_n_o` is driven to 0.
- R8: While `busy_n_i` is 1 now and was 1 in the previous cycle, each change of `ack_n_i` inverts `req_n_o` and arms an interrupt.
- R9: With `irq_bypass_i` at 0, `sr_irq_o` pulses for one cycle DELAY_CYCLES edges after the edge that armed it. Arming it again before it fires restarts the wait, so only one pulse results.
- R10: With `irq_bypass_i` at 1, `sr_irq_o` pulses on the edge that arms it, one pulse per arming.
- R11: `rsp_load_i` sets the response length to `rsp_len_i` (limited to DEPTH), resets the read index to 0, drives `req_n_o` to 0 and arms an interrupt. Response bytes are written beforehand with `rsp_wr_en_i`.
- R12: `pkt_rd_data_o` shows the packet byte at `pkt_rd_addr_i` one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_n_i | input | 1 | Host acknowledge line, active low |
| busy_n_i | input | 1 | Host transfer-in-progress line, active low |
| host_to_dev_i | input | 1 | 1: host sends bytes, 0: host fetches bytes |
| irq_bypass_i | input | 1 | 1: shift interrupt without delay |
| shift_in_i | input | DATA_W | Byte the host has placed in the shift register |
| shift_out_o | output | DATA_W | Response byte presented to the host |
| req_n_o | output | 1 | Device request line, active low |
| sr_irq_o | output | 1 | One-cycle shift interrupt pulse |
| rsp_wr_en_i | input | 1 | Write enable for the response buffer |
| rsp_wr_addr_i | input | AW | Response buffer write index |
| rsp_wr_data_i | input | DATA_W | Response byte to store |
| rsp_load_i | input | 1 | Start a response of `rsp_len_i` bytes |
| rsp_len_i | input | LW | Response length in bytes |
| pkt_done_o | output | 1 | One-cycle pulse: packet received |
| pkt_len_o | output | LW | Length of the received packet |
| pkt_rd_addr_i | input | AW | Packet buffer read index |
| pkt_rd_data_o | output | DATA_W | Packet byte, one cycle after the address |

## Verification
Sending is exercised in three ways: with bytes paced by acknowledge toggles alone, with a first byte taken on the busy edge itself, and with one byte more than the buffer holds. Together these separate edge detection on each line from bounds handling and from the packet length that is reported. Fetching is run to exhaustion and past it, which shows whether the request line is released exactly on the last byte and whether surplus toggles are ignored. A separate run leaves bytes pending when the transfer ends, to check that the request line is reasserted. Idle acknowledge toggles, an empty transfer, and interrupt timing in delayed, restarted and bypass modes separate the interrupt sources from one another.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef struct packed {
    logic busy_n;
    logic ack_n;
  } hs_lines_t;

  localparam hs_lines_t HS_IDLE = '{busy_n: 1'b1, ack_n: 1'b1};
endpackage

// File: rtl/hs_sdp_ram.sv
module hs_sdp_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hs_line_tracker.sv
module hs_line_tracker
  import hs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ack_n,
  input  logic busy_n,
  output logic busy_now,
  output logic busy_was,
  output logic ack_chg,
  output logic any_chg
);
  hs_lines_t cur, prev;

  assign cur = '{busy_n: busy_n, ack_n: ack_n};

  always_ff @(posedge clk) begin
    if (rst) prev <= HS_IDLE;
    else     prev <= cur;
  end

  assign busy_now = ~cur.busy_n;
  assign busy_was = ~prev.busy_n;
  assign ack_chg  = cur.ack_n ^ prev.ack_n;
  assign any_chg  = (cur.ack_n ^ prev.ack_n) | (cur.busy_n ^ prev.busy_n);
endmodule

// File: rtl/hs_irq_delay.sv
module hs_irq_delay #(
  parameter int DELAY_CYCLES = 75000,
  localparam int CW = $clog2(DELAY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic sched,
  input  logic bypass,
  output logic irq
);
  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (sched) begin
        if (bypass) begin
          irq   <= 1'b1;
          armed <= 1'b0;
        end else begin
          cnt   <= CW'(DELAY_CYCLES);
          armed <= 1'b1;
        end
      end else if (armed) begin
        if (cnt <= CW'(1)) begin
          irq   <= 1'b1;
          armed <= 1'b0;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end

  AST_IRQ_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (sched && bypass) |=> irq);  // R10
  AST_IRQ_DUE: assert property (@(posedge clk) disable iff (rst)
    (armed && cnt == CW'(1) && !sched) |=> irq);  // R9
  AST_IRQ_CAUSED: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(sched) || $past(armed)));  // R9
endmodule

// File: rtl/hs_xfer_engine.sv
module hs_xfer_engine
  import hs_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int DATA_W       = 8,
  parameter int DELAY_CYCLES = 75000,
  localparam int AW          = $clog2(DEPTH),
  localparam int LW          = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_n_i,
  input  logic              busy_n_i,
  input  logic              host_to_dev_i,
  input  logic              irq_bypass_i,
  input  logic [DATA_W-1:0] shift_in_i,
  output logic [DATA_W-1:0] shift_out_o,
  output logic              req_n_o,
  output logic              sr_irq_o,
  input  logic              rsp_wr_en_i,
  input  logic [AW-1:0]     rsp_wr_addr_i,
  input  logic [DATA_W-1:0] rsp_wr_data_i,
  input  logic              rsp_load_i,
  input  logic [LW-1:0]     rsp_len_i,
  output logic              pkt_done_o,
  output logic [LW-1:0]     pkt_len_o,
  input  logic [AW-1:0]     pkt_rd_addr_i,
  output logic [DATA_W-1:0] pkt_rd_data_o
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic busy_now, busy_was, ack_chg, any_chg;
  logic [LW-1:0] out_idx, in_idx, in_idx_next, in_len;
  logic [DATA_W-1:0] in_q;
  logic tx_take, rx_take, end_xfer, idle_tog, sched;

  hs_line_tracker u_lines (
    .clk      (clk),
    .rst      (rst),
    .ack_n    (ack_n_i),
    .busy_n   (busy_n_i),
    .busy_now (busy_now),
    .busy_was (busy_was),
    .ack_chg  (ack_chg),
    .any_chg  (any_chg)
  );

  assign tx_take  = busy_now && host_to_dev_i && any_chg && (out_idx < FULL);
  assign rx_take  = busy_now && !host_to_dev_i && any_chg && (in_idx < in_len);
  assign end_xfer = !busy_now && busy_was;
  assign idle_tog = !busy_now && !busy_was && ack_chg;
  assign sched    = tx_take | rx_take | end_xfer | idle_tog | rsp_load_i;

  always_comb begin
    in_idx_next = in_idx;
    if (rsp_load_i)   in_idx_next = '0;
    else if (rx_take) in_idx_next = in_idx + LW'(1);
  end

  // Host-to-device packet storage
  hs_sdp_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_pkt_ram (
    .clk   (clk),
    .we    (tx_take),
    .waddr (out_idx[AW-1:0]),
    .wdata (shift_in_i),
    .raddr (pkt_rd_addr_i),
    .rdata (pkt_rd_data_o)
  );

  // Device-to-host response storage; read one index ahead
  hs_sdp_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rsp_ram (
    .clk   (clk),
    .we    (rsp_wr_en_i),
    .waddr (rsp_wr_addr_i),
    .wdata (rsp_wr_data_i),
    .raddr (in_idx_next[AW-1:0]),
    .rdata (in_q)
  );

  hs_irq_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .sched  (sched),
    .bypass (irq_bypass_i),
    .irq    (sr_irq_o)
  );

  // Capture side
  always_ff @(posedge clk) begin
    if (rst) begin
      out_idx    <= '0;
      pkt_done_o <= 1'b0;
      pkt_len_o  <= '0;
    end else begin
      pkt_done_o <= 1'b0;
      if (tx_take) begin
        out_idx <= out_idx + LW'(1);
      end else if (end_xfer) begin
        if (out_idx != '0) begin
          pkt_done_o <= 1'b1;
          pkt_len_o  <= out_idx;
        end
        out_idx <= '0;
      end
    end
  end

  // Response side and request line
  always_ff @(posedge clk) begin
    if (rst) begin
      in_idx      <= '0;
      in_len      <= '0;
      shift_out_o <= '0;
      req_n_o     <= 1'b1;
    end else begin
      in_idx <= in_idx_next;
      if (rsp_load_i) begin
        in_len  <= (rsp_len_i > FULL) ? FULL : rsp_len_i;
        req_n_o <= 1'b0;
      end else if (rx_take) begin
        shift_out_o <= in_q;
        if (in_idx + LW'(1) == in_len) req_n_o <= 1'b1;
      end else if (end_xfer) begin
        if (in_idx < in_len) req_n_o <= 1'b0;
      end else if (idle_tog) begin
        req_n_o <= ~req_n_o;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_n_o && !sr_irq_o && !pkt_done_o));  // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    out_idx <= FULL);  // R3
  AST_IN_BOUND: assert property (@(posedge clk) disable iff (rst)
    in_idx <= in_len);  // R4
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (rx_take && !rsp_load_i && (in_idx + LW'(1) == in_len)) |=> req_n_o);  // R5
  AST_PKT_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    pkt_done_o |-> (pkt_len_o != '0));  // R6
  AST_IDLE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (idle_tog && !rsp_load_i) |=> (req_n_o != $past(req_n_o)));  // R8
endmodule

// File: tb/tb_hs_xfer_engine.sv
`timescale 1ns/1ps
module tb_hs_xfer_engine;
  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int DLY   = 10;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic ack_n = 1'b1, busy_n = 1'b1, h2d = 1'b0, byp = 1'b0;
  logic [DW-1:0] sin = '0, sout;
  logic req_n, irq;
  logic rwe = 1'b0, rload = 1'b0;
  logic [AW-1:0] rwa = '0, pra = '0;
  logic [DW-1:0] rwd = '0, prd;
  logic [LW-1:0] rlen = '0, plen;
  logic pdone;

  int tests = 0, fails = 0;
  int irq_seen = 0, pkt_seen = 0;
  int last_len = 0;

  always #2 clk = ~clk;

  hs_xfer_engine #(.DEPTH(DEPTH), .DATA_W(DW), .DELAY_CYCLES(DLY)) dut (
    .clk(clk), .rst(rst), .ack_n_i(ack_n), .busy_n_i(busy_n),
    .host_to_dev_i(h2d), .irq_bypass_i(byp), .shift_in_i(sin),
    .shift_out_o(sout), .req_n_o(req_n), .sr_irq_o(irq),
    .rsp_wr_en_i(rwe), .rsp_wr_addr_i(rwa), .rsp_wr_data_i(rwd),
    .rsp_load_i(rload), .rsp_len_i(rlen), .pkt_done_o(pdone),
    .pkt_len_o(plen), .pkt_rd_addr_i(pra), .pkt_rd_data_o(prd)
  );

  always @(negedge clk) begin
    if (!rst && irq) irq_seen++;
    if (!rst && pdone) begin pkt_seen++; last_len = int'(plen); end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_ack();
    @(negedge clk); ack_n = ~ack_n;
  endtask

  task automatic wait_irq(output int when);
    when = -1;
    for (int i = 1; i <= DLY + 4; i++) begin
      @(posedge clk); #1;
      if (irq && when < 0) when = i;
    end
  endtask

  task automatic load_rsp(input logic [DW-1:0] b0, input logic [DW-1:0] b1,
                          input logic [DW-1:0] b2, input int n);
    logic [DW-1:0] v [3];
    v[0] = b0; v[1] = b1; v[2] = b2;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); rwe = 1'b1; rwa = AW'(k); rwd = v[k];
    end
    @(negedge clk); rwe = 1'b0; rload = 1'b1; rlen = LW'(n);
    @(negedge clk); rload = 1'b0;
  endtask

  task automatic read_pkt(input int a, output int d);
    @(negedge clk); pra = AW'(a);
    @(negedge clk); d = int'(prd);
  endtask

  task automatic t_reset();
    chk(req_n == 1'b1, "R1 req_n", req_n, 1);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(pdone == 1'b0, "R1 pkt_done", pdone, 0);
    chk(sout == '0, "R1 shift_out", sout, 0);
  endtask

  task automatic t_delay();
    int w, base;
    byp = 1'b0;
    base = irq_seen;
    toggle_ack();
    wait_irq(w);
    chk(w == DLY + 1, "R9 delay", w, DLY + 1);
    toggle_ack();
    tick(4);
    toggle_ack();
    wait_irq(w);
    chk(w == DLY + 1, "R9 restart delay", w, DLY + 1);
    chk(irq_seen - base == 2, "R9 pulse count", irq_seen - base, 2);
    byp = 1'b1;
    toggle_ack();
    wait_irq(w);
    chk(w == 1, "R10 bypass", w, 1);
  endtask

  task automatic t_idle_toggle();
    int base;
    logic r0;
    tick(2);
    r0 = req_n; base = irq_seen;
    toggle_ack(); tick(2);
    chk(req_n == ~r0, "R8 req toggles", req_n, ~r0);
    chk(irq_seen - base == 1, "R8 irq", irq_seen - base, 1);
    toggle_ack(); tick(2);
    chk(req_n == r0, "R8 req toggles back", req_n, r0);
  endtask

  task automatic t_send();
    int base, d;
    logic [DW-1:0] v [3];
    v[0] = 8'hA0; v[1] = 8'hB1; v[2] = 8'hC2;
    h2d = 1'b1; base = irq_seen;
    @(negedge clk); sin = v[0]; busy_n = 1'b0;
    for (int k = 1; k < 3; k++) begin
      tick(1); sin = v[k]; ack_n = ~ack_n;
    end
    tick(3);
    chk(irq_seen - base == 3, "R2 irq per byte", irq_seen - base, 3);
    base = pkt_seen;
    @(negedge clk); busy_n = 1'b1;
    tick(3);
    chk(pkt_seen - base == 1, "R6 pkt_done once", pkt_seen - base, 1);
    chk(last_len == 3, "R6 pkt_len", last_len, 3);
    for (int k = 0; k < 3; k++) begin
      read_pkt(k, d);
      chk(d == int'(v[k]), "R2/R12 pkt byte", d, int'(v[k]));
    end
  endtask

  task automatic t_overflow();
    int base, d;
    h2d = 1'b1; base = irq_seen;
    @(negedge clk); sin = 8'h40; busy_n = 1'b0;
    for (int k = 1; k <= DEPTH; k++) begin
      tick(1); sin = DW'(8'h40 + k); ack_n = ~ack_n;
    end
    tick(3);
    chk(irq_seen - base == DEPTH, "R3 no irq when full", irq_seen - base, DEPTH);
    base = irq_seen;
    @(negedge clk); busy_n = 1'b1;
    tick(3);
    chk(irq_seen - base == 1, "R6 end irq", irq_seen - base, 1);
    chk(last_len == DEPTH, "R3 pkt_len full", last_len, DEPTH);
    read_pkt(0, d);
    chk(d == 8'h40, "R3 no overwrite", d, 8'h40);
    read_pkt(DEPTH - 1, d);
    chk(d == 8'h40 + DEPTH - 1, "R3 last byte", d, 8'h40 + DEPTH - 1);
  endtask

  task automatic t_empty();
    int base, pbase;
    h2d = 1'b0; base = irq_seen; pbase = pkt_seen;
    @(negedge clk); busy_n = 1'b0;
    tick(2);
    @(negedge clk); busy_n = 1'b1;
    tick(3);
    chk(irq_seen - base == 1, "R6 empty end irq", irq_seen - base, 1);
    chk(pkt_seen == pbase, "R6 no pkt when empty", pkt_seen - pbase, 0);
  endtask

  task automatic t_receive();
    int base;
    h2d = 1'b0;
    base = irq_seen;
    @(negedge clk); ack_n = 1'b1;
    tick(2);
    load_rsp(8'h11, 8'h22, 8'h33, 3);
    tick(1);
    chk(req_n == 1'b0, "R11 req low on load", req_n, 0);
    chk(irq_seen - base == 1, "R11 load irq", irq_seen - base, 1);
    base = irq_seen;
    @(negedge clk); busy_n = 1'b0;
    tick(1);
    chk(sout == 8'h11, "R4 first byte", sout, 8'h11);
    chk(req_n == 1'b0, "R5 req held", req_n, 0);
    toggle_ack(); tick(1);
    chk(sout == 8'h22, "R4 second byte", sout, 8'h22);
    toggle_ack(); tick(1);
    chk(sout == 8'h33, "R4 third byte", sout, 8'h33);
    chk(req_n == 1'b1, "R5 req released on last", req_n, 1);
    toggle_ack(); tick(3);
    chk(sout == 8'h33, "R4 ignored when empty", sout, 8'h33);
    chk(irq_seen - base == 3, "R4 irq count", irq_seen - base, 3);
    @(negedge clk); busy_n = 1'b1;
    tick(2);
    chk(req_n == 1'b1, "R7 nothing pending", req_n, 1);
  endtask

  task automatic t_pending();
    load_rsp(8'h5A, 8'h6B, 8'h7C, 3);
    toggle_ack(); tick(2);
    chk(req_n == 1'b1, "R8 req toggled high", req_n, 1);
    h2d = 1'b0;
    @(negedge clk); busy_n = 1'b0;
    tick(1);
    chk(sout == 8'h5A, "R4 byte before end", sout, 8'h5A);
    chk(req_n == 1'b1, "R7 req still high", req_n, 1);
    @(negedge clk); busy_n = 1'b1;
    tick(2);
    chk(req_n == 1'b0, "R7 req reasserted", req_n, 0);
  endtask

  initial begin
    tick(3);
    @(negedge clk); rst = 1'b0;
    tick(1);
    t_reset();
    t_delay();
    t_idle_toggle();
    t_send();
    t_overflow();
    t_empty();
    t_receive();
    t_pending();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    tests++; fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule